// File: doc/BRIEF.md
# Multiplexed External Bus Controller with Dynamic Width

This block connects a 16-bit core to an external memory over a shared address/data bus. The core places one request at a time on a request/acknowledge port. Each request carries an address, write data, a byte-or-word size, a direction and an instruction-fetch flag. The controller then runs one or two external bus cycles, each made of an address state followed by one or more data states. It drives the address strobe, the read and write strobes, the byte-lane strobe and the fetch indicator.

The width of each bus cycle is fixed at 8 bits unless dynamic sizing is enabled. With dynamic sizing on, the width is taken from an input pin when the cycle completes. A slow device can hold the data state open by pulling a ready input low. An external master can claim the bus through an active-low hold request. The controller grants it only between cycles and floats the bus. While the grant is in force, it signals through a bus-request output that the core is waiting on an external access.

Top module: `mxbus_ctrl`

## Requirements
- R1: With cfg_dyn_width low every bus cycle is 8 bits wide. With it high, buswidth is sampled on the clock that completes the data state: 1 makes the cycle 16 bits wide and 0 makes it 8 bits wide.
- R2: With cfg_split_wr low, bhe_n is valid for the whole cycle. A byte cycle drives bhe_n = NOT address bit 0, so an even address selects the low lane only and an odd address selects the high lane only. The first cycle of a word request at an even address drives bhe_n = 0 with address bit 0 = 0, which selects both lanes.
- R3: With cfg_split_wr low, wr_n goes low in the data states of every write. With it high, wr_n acts as the low-lane write strobe and goes low only when address bit 0 = 0. In that mode bhe_n acts as the high-lane write strobe and goes low only when the high lane is written. Both stay high on reads.
- R4: With cfg_adv low, as_o is high for exactly the address state of each bus cycle and low otherwise. With cfg_adv high, as_o is low from the address state through the last data state and high in every other state.
- R5: inst equals req_fetch during the address and data states of an external cycle and is low at all other times.
- R6: When onchip_sel is high, a request to an address from 2000h to 5FFFh produces no bus cycle. Such a request is acknowledged one clock after it is presented, with read data zero.
- R7: Each clock on which ready is sampled low in a data state adds one data state. A request that needs C bus cycles with W waits per cycle is acknowledged C*(2+W)+1 clocks after it is presented.
- R8: hold_n is registered and takes effect only while no cycle is in progress. While hlda_n is low, ad_oe is low, rd_n, wr_n and bhe_n are high, inst is low and as_o is inactive. A two-cycle word transfer is never separated by a grant.
- R9: While hlda_n is low and an external request is pending, breq_n is low. Otherwise breq_n is high.
- R10: A word request at an odd address, or a word request on an 8-bit cycle, becomes two byte cycles: the low byte at the request address first, then the high byte at that address plus one.
- R11: On a 16-bit cycle, a byte at an odd address is read from ad_in[15:8]. On an 8-bit cycle, every byte is read from ad_in[7:0]. Byte reads are zero-extended, and word halves are merged before the acknowledge.
- R12: req_ack is a single-clock pulse that ends each request. After reset, no strobe is active, the bus is not driven and hlda_n and breq_n are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dyn_width | input | 1 | Enable per-cycle width from buswidth |
| cfg_adv | input | 1 | Strobe mode: 0 pulse-high, 1 low-for-cycle |
| cfg_split_wr | input | 1 | 1: separate low/high lane write strobes |
| onchip_sel | input | 1 | Route 2000h-5FFFh to on-chip memory |
| req_valid | input | 1 | Request pending, held until req_ack |
| req_addr | input | 16 | Request byte address |
| req_wdata | input | 16 | Write data |
| req_word | input | 1 | 1 word, 0 byte |
| req_write | input | 1 | 1 write, 0 read |
| req_fetch | input | 1 | Instruction fetch flag |
| req_ack | output | 1 | Request complete pulse |
| req_rdata | output | 16 | Read data |
| ad_out | output | 16 | Multiplexed address/data out |
| ad_oe | output | 1 | Bus output enable |
| ad_in | input | 16 | Multiplexed bus data in |
| as_o | output | 1 | Address strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe or low-lane write strobe |
| bhe_n | output | 1 | High-lane enable or high-lane write strobe |
| inst | output | 1 | Fetch indicator |
| ready | input | 1 | Low adds a wait state |
| buswidth | input | 1 | Width pin, 1 = 16-bit cycle |
| hold_n | input | 1 | Bus hold request, active low |
| hlda_n | output | 1 | Hold grant, active low |
| breq_n | output | 1 | Pending-access request in hold, active low |

## Verification
Inputs change and outputs are read at the falling edge, so each result is read at the first falling edge after the rising edge that produces it. The address state appears one falling edge after a request is presented and the first data state one edge later. The acknowledge arrives C*(2+W)+1 edges after the request, and the bench compares the observed edge count with that formula. A bus model answers each read from its own byte memory and applies each write according to the lane strobes it sees. The bench drives ready from its own wait counter, so wait states match the count it expects. A hold grant is checked two falling edges after hold_n falls. The bus request is checked on the edge after a request is raised during the grant.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_HOLD} mx_state_t;
  localparam logic [15:0] LOCAL_LO = 16'h2000;
  localparam logic [15:0] LOCAL_HI = 16'h5FFF;
endpackage

// File: rtl/mxbus_seq.sv
module mxbus_seq
  import mxbus_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req_valid,
  input  logic      req_word,
  input  logic      req_lo_bit,
  input  logic      req_local,
  input  logic      hold_n,
  input  logic      ready,
  input  logic      bus_is16,
  output mx_state_t state,
  output logic      phase,
  output logic      cyc_done,
  output logic      local_go,
  output logic      ack,
  output logic      hlda_n,
  output logic      breq_n
);
  logic hold_q;
  logic more;

  assign cyc_done = (state == S_DATA) && ready;
  assign more     = req_word && !phase && (req_lo_bit || !bus_is16);
  assign local_go = (state == S_IDLE) && !hold_q && req_valid && !ack && req_local;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      phase  <= 1'b0;
      ack    <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= ~hold_n;
      ack    <= 1'b0;
      case (state)
        S_IDLE: begin
          if (hold_q) state <= S_HOLD;
          else if (req_valid && !ack) begin
            if (req_local) ack <= 1'b1;
            else begin
              state <= S_ADDR;
              phase <= 1'b0;
            end
          end
        end
        S_ADDR: state <= S_DATA;
        S_DATA: begin
          if (ready) begin
            if (more) begin
              phase <= 1'b1;
              state <= S_ADDR;
            end else begin
              state <= S_IDLE;
              ack   <= 1'b1;
            end
          end
        end
        default: if (!hold_q) state <= S_IDLE;
      endcase
    end
  end

  assign hlda_n = ~(state == S_HOLD);
  assign breq_n = ~((state == S_HOLD) && req_valid && !req_local);

  // R8: a grant is only entered from the idle state
  p_grant_from_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_HOLD && $past(state) != S_HOLD) |-> $past(state) == S_IDLE);
  // R7: a low ready keeps the data state
  p_wait_stretch_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_DATA && !ready) |=> state == S_DATA);
endmodule

// File: rtl/mxbus_lane.sv
module mxbus_lane
  import mxbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  mx_state_t       state,
  input  logic            phase,
  input  logic [DW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic            req_word,
  input  logic            req_write,
  input  logic            req_fetch,
  input  logic            cfg_adv,
  input  logic            cfg_split_wr,
  output logic [DW-1:0]   ad_out,
  output logic            ad_oe,
  output logic            as_o,
  output logic            rd_n,
  output logic            wr_n,
  output logic            bhe_n,
  output logic            inst,
  output logic            cyc_a0
);
  localparam int BW = DW / 2;

  logic [DW-1:0] cyc_addr;
  logic          active, in_data, wr_act, both, lo_lane, hi_lane;
  logic [BW-1:0] sel_byte;

  assign cyc_addr = req_addr + {{(DW-1){1'b0}}, phase};
  assign cyc_a0   = cyc_addr[0];
  assign in_data  = (state == S_DATA);
  assign active   = (state == S_ADDR) || in_data;
  assign wr_act   = in_data && req_write;
  assign both     = req_word && !phase && !cyc_a0;
  assign lo_lane  = !cyc_a0;
  assign hi_lane  = cyc_a0 || both;
  assign sel_byte = phase ? req_wdata[DW-1:BW] : req_wdata[BW-1:0];

  always_comb begin
    ad_out = '0;
    if (state == S_ADDR) ad_out = cyc_addr;
    else if (wr_act)     ad_out = both ? req_wdata : {sel_byte, sel_byte};
  end

  assign ad_oe = (state == S_ADDR) || wr_act;
  assign as_o  = cfg_adv ? !active : (state == S_ADDR);
  assign rd_n  = !(in_data && !req_write);
  assign wr_n  = !(wr_act && (!cfg_split_wr || lo_lane));
  assign bhe_n = cfg_split_wr ? !(wr_act && hi_lane) : !(active && hi_lane);
  assign inst  = active && req_fetch;
endmodule

// File: rtl/mxbus_rdmerge.sv
module mxbus_rdmerge #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_done,
  input  logic          local_go,
  input  logic          phase,
  input  logic          req_word,
  input  logic          cyc_a0,
  input  logic          bus_is16,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] rdata
);
  localparam int BW = DW / 2;
  logic [BW-1:0] lane_byte;
  logic          full;

  assign lane_byte = (bus_is16 && cyc_a0) ? ad_in[DW-1:BW] : ad_in[BW-1:0];
  assign full      = req_word && !phase && !cyc_a0 && bus_is16;

  always_ff @(posedge clk) begin
    if (rst || local_go) rdata <= '0;
    else if (cyc_done) begin
      if (full)           rdata <= ad_in;
      else if (!req_word) rdata <= {{BW{1'b0}}, lane_byte};
      else if (!phase)    rdata[BW-1:0] <= lane_byte;
      else                rdata[DW-1:BW] <= lane_byte;
    end
  end
endmodule

// File: rtl/mxbus_ctrl.sv
module mxbus_ctrl
  import mxbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_dyn_width,
  input  logic          cfg_adv,
  input  logic          cfg_split_wr,
  input  logic          onchip_sel,
  input  logic          req_valid,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_word,
  input  logic          req_write,
  input  logic          req_fetch,
  output logic          req_ack,
  output logic [DW-1:0] req_rdata,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic          as_o,
  output logic          rd_n,
  output logic          wr_n,
  output logic          bhe_n,
  output logic          inst,
  input  logic          ready,
  input  logic          buswidth,
  input  logic          hold_n,
  output logic          hlda_n,
  output logic          breq_n
);
  mx_state_t state;
  logic phase, cyc_done, local_go, bus_is16, req_local, cyc_a0;

  assign bus_is16  = cfg_dyn_width && buswidth;
  assign req_local = onchip_sel && (req_addr >= DW'(LOCAL_LO)) && (req_addr <= DW'(LOCAL_HI));

  mxbus_seq u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_word(req_word),
    .req_lo_bit(req_addr[0]), .req_local(req_local), .hold_n(hold_n),
    .ready(ready), .bus_is16(bus_is16), .state(state), .phase(phase),
    .cyc_done(cyc_done), .local_go(local_go), .ack(req_ack),
    .hlda_n(hlda_n), .breq_n(breq_n));

  mxbus_lane #(.DW(DW)) u_lane (
    .state(state), .phase(phase), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_word(req_word), .req_write(req_write), .req_fetch(req_fetch),
    .cfg_adv(cfg_adv), .cfg_split_wr(cfg_split_wr), .ad_out(ad_out),
    .ad_oe(ad_oe), .as_o(as_o), .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n),
    .inst(inst), .cyc_a0(cyc_a0));

  mxbus_rdmerge #(.DW(DW)) u_rd (
    .clk(clk), .rst(rst), .cyc_done(cyc_done), .local_go(local_go),
    .phase(phase), .req_word(req_word), .cyc_a0(cyc_a0), .bus_is16(bus_is16),
    .ad_in(ad_in), .rdata(req_rdata));

  // R8: bus quiet during a grant
  p_hold_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !hlda_n |-> (rd_n && wr_n && bhe_n && !ad_oe && !inst));
  // R8: a grant never begins while a strobe was active
  p_hold_boundary_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(hlda_n) |-> $past(rd_n && wr_n && bhe_n));
  // R9: bus request only while granted
  p_breq_r9: assert property (@(posedge clk) disable iff (rst)
    !breq_n |-> !hlda_n);
  // R12: acknowledge is a single pulse
  p_ack_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);
  // R5: fetch indicator only in external cycles
  p_inst_r5: assert property (@(posedge clk) disable iff (rst)
    inst |-> (ad_oe || !rd_n));
  // R7: read strobe held while ready is low
  p_wait_rd_r7: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !ready) |=> !rd_n);
endmodule

// File: tb/mxbus_ctrl_tb.sv
module mxbus_ctrl_tb;
  logic clk = 0, rst = 1;
  logic cfg_dyn_width = 0, cfg_adv = 0, cfg_split_wr = 0, onchip_sel = 0;
  logic req_valid = 0, req_word = 0, req_write = 0, req_fetch = 0;
  logic [15:0] req_addr = 0, req_wdata = 0, ad_in = 0;
  logic ready = 1, buswidth = 0, hold_n = 1;
  logic req_ack, ad_oe, as_o, rd_n, wr_n, bhe_n, inst, hlda_n, breq_n;
  logic [15:0] req_rdata, ad_out;
  logic [7:0] bmem [256];
  logic [7:0] emem [256];
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  mxbus_ctrl u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_cycles(input logic [15:0] a, input bit word, input bit e16, input bit loc);
    if (loc) return 0;
    return (word && !(e16 && !a[0])) ? 2 : 1;
  endfunction

  task automatic txn(input logic [15:0] a, input bit word, input bit wr, input bit fetch,
                     input logic [15:0] wd, input bit bw, input int w, input int hmode);
    int n = 0, cyc = 0, ascnt = 0, wcnt = 0, ecyc;
    bit got = 0, inst_bad = 0, hlda_bad = 0, hset = 0, bhe_first = 1, dp, asact, e16, loc;
    logic [15:0] lat = 0, erd;
    logic [7:0] i0, i1;
    i0 = a[7:0]; i1 = a[7:0] + 8'd1;
    loc = onchip_sel && a >= 16'h2000 && a <= 16'h5FFF;
    e16 = cfg_dyn_width && bw;
    buswidth = bw;
    if (hmode == 1) begin
      hold_n = 0;
      @(negedge clk); @(negedge clk);
      chk(hlda_n == 0, "R8 grant", hlda_n, 0);
      chk(!ad_oe && rd_n && wr_n && bhe_n && !inst, "R8 quiet", {ad_oe, rd_n, wr_n, bhe_n, inst}, 5'b01110);
    end
    req_addr = a; req_word = word; req_write = wr; req_fetch = fetch; req_wdata = wd; req_valid = 1;
    if (hmode == 1) begin
      @(negedge clk);
      chk(breq_n == (loc ? 1'b1 : 1'b0), "R9 breq", breq_n, loc);
      chk(!ad_oe, "R8 no cycle in hold", ad_oe, 0);
      hold_n = 1;
    end
    while (!got && n < 80) begin
      @(negedge clk); n++;
      dp = !rd_n || !wr_n || (cfg_split_wr && !bhe_n);
      asact = cfg_adv ? !as_o : as_o;
      if (asact) ascnt++;
      if (hmode == 2 && !hlda_n) hlda_bad = 1;
      if (asact && !dp && ad_oe) begin
        cyc++; lat = ad_out; wcnt = 0;
        if (cyc == 1) bhe_first = bhe_n;
        if (inst !== fetch) inst_bad = 1;
      end
      if (dp) begin
        if (inst !== fetch) inst_bad = 1;
        if (hmode == 2 && !hset) begin hold_n = 0; hset = 1; end
        ready = (wcnt >= w); wcnt++;
        ad_in = e16 ? {bmem[{lat[7:1], 1'b1}], bmem[{lat[7:1], 1'b0}]} : {8'hEE, bmem[lat[7:0]]};
        if (ready && wr) begin
          if (e16) begin
            if (cfg_split_wr ? !wr_n : (!wr_n && !lat[0])) bmem[{lat[7:1], 1'b0}] = ad_out[7:0];
            if (cfg_split_wr ? !bhe_n : (!wr_n && !bhe_n)) bmem[{lat[7:1], 1'b1}] = ad_out[15:8];
          end else bmem[lat[7:0]] = ad_out[7:0];
        end
      end
      if (!asact && !dp && inst) inst_bad = 1;
      if (req_ack) got = 1;
    end
    req_valid = 0; ready = 1;
    ecyc = exp_cycles(a, word, e16, loc);
    chk(got, "R12 ack seen", got, 1);
    chk(cyc == ecyc, loc ? "R6 no bus cycle" : "R10 R1 cycle count", cyc, ecyc);
    if (hmode != 1)
      chk(n == (loc ? 1 : ecyc * (2 + w) + 1), loc ? "R6 latency" : "R7 latency", n, loc ? 1 : ecyc * (2 + w) + 1);
    chk(ascnt == (cfg_adv ? ecyc * (2 + w) : ecyc), "R4 strobe states", ascnt, cfg_adv ? ecyc * (2 + w) : ecyc);
    chk(!inst_bad, "R5 inst", inst_bad, 0);
    if (!wr) begin
      erd = loc ? 16'h0 : (word ? {emem[i1], emem[i0]} : {8'h00, emem[i0]});
      chk(req_rdata == erd, "R11 read data", req_rdata, erd);
    end else if (!loc) begin
      emem[i0] = wd[7:0];
      if (word) emem[i1] = wd[15:8];
      chk(bmem[i0] == emem[i0] && bmem[i1] == emem[i1], "R3 write lanes",
          {bmem[i1], bmem[i0]}, {emem[i1], emem[i0]});
    end
    if (!loc && !cfg_split_wr)
      chk(bhe_first == ((word && !a[0]) ? 1'b0 : ~a[0]), "R2 lane enable", bhe_first, (word && !a[0]) ? 1'b0 : ~a[0]);
    if (hmode == 2) begin
      chk(!hlda_bad, "R8 no grant mid cycle", hlda_bad, 0);
      @(negedge clk);
      chk(hlda_n == 0, "R8 grant after cycle", hlda_n, 0);
      hold_n = 1;
      @(negedge clk); @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      bmem[i] = 8'(i * 7 + 3);
      emem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk(!req_ack && !ad_oe && rd_n && wr_n && bhe_n && !as_o && hlda_n && breq_n,
        "R12 reset state", {req_ack, ad_oe, rd_n, wr_n, bhe_n, as_o, hlda_n, breq_n}, 8'b00111011);
    rst = 0;
    @(negedge clk);
    // R1: width chosen by configuration and pin
    cfg_dyn_width = 0; txn(16'h0010, 1, 0, 0, 0, 1, 0, 0);
    cfg_dyn_width = 1; txn(16'h0010, 1, 0, 1, 0, 1, 0, 0);
    txn(16'h0010, 1, 0, 0, 0, 0, 0, 0);
    // R10: odd word on a 16-bit cycle is split
    txn(16'h0021, 1, 0, 0, 0, 1, 1, 0);
    txn(16'h0033, 1, 1, 0, 16'hBEEF, 1, 0, 0);
    // R3: separate lane strobes
    cfg_split_wr = 1;
    txn(16'h0041, 0, 1, 0, 16'h005A, 1, 0, 0);
    txn(16'h0044, 1, 1, 0, 16'hC3A5, 1, 2, 0);
    txn(16'h0047, 1, 1, 0, 16'h1234, 0, 0, 0);
    cfg_split_wr = 0;
    // R4: low-for-cycle strobe with waits
    cfg_adv = 1; txn(16'h0050, 1, 0, 1, 0, 1, 3, 0); cfg_adv = 0;
    // R6: on-chip range
    onchip_sel = 1; txn(16'h3000, 1, 0, 0, 0, 1, 0, 0);
    txn(16'h5FFF, 0, 1, 0, 16'h00AA, 1, 0, 0);
    onchip_sel = 0; txn(16'h3002, 1, 0, 0, 0, 1, 0, 0);
    // R8 R9: hold before and during a cycle
    txn(16'h0060, 0, 0, 0, 0, 1, 0, 1);
    txn(16'h0063, 1, 0, 1, 0, 0, 2, 2);
    for (int k = 0; k < 60; k++) begin
      logic [15:0] ra;
      cfg_dyn_width = 1'($urandom); cfg_adv = 1'($urandom);
      cfg_split_wr = 1'($urandom); onchip_sel = 1'($urandom);
      ra = ($urandom % 3 == 0) ? 16'h2000 + 16'($urandom % 16'h3F00) : {8'h00, 8'($urandom)};
      txn(ra, 1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), 1'($urandom),
          int'($urandom % 3), (k % 10 == 9) ? 1 : 0);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule